// File: doc/BRIEF.md
# Pixel Row Sequencing Controller

This block steps a pixel sensor matrix through row-by-row readout. Every row has two control lines, a select (gate) line that switches the row's pixel transistors onto the column readout and a clear line that empties the charge stored in those pixels. For each row the controller runs one fixed sequence. It raises the row's gate, requests a first sample (signal plus pedestal), pulses the row's clear line, requests a second sample (pedestal only), and then moves to the next row. The readout stage subtracts the two samples.

A scan starts at a chosen row and climbs to the last row of the matrix. It then flags the end of the frame and wraps back to the chosen row for as long as `run` stays high. Scans happen only during a bunch train; between trains `run` is dropped so that the current row completes and every line goes quiet. A separate power-down input stops everything at the next edge. The length of each phase is set in clock cycles, so the row period can be tuned to the required row rate.

Top module: `rowseq_ctrl`

## Requirements
- R1: While `rst` is high, and afterwards until a scan is started, every gate and clear line, both sample strobes and `frame_done` are low.
- R2: A row's sequence consists of four phases in a fixed order: setup (gate only) for `cfg_setup` cycles, `smp_a` for `cfg_sample` cycles, clear for `cfg_clear` cycles, then `smp_b` for `cfg_sample` cycles. A setting of 0 counts as 1 cycle. The row's gate stays high through all four phases.
- R3: At most one gate line and at most one clear line are high in any cycle. A high clear line belongs to the row whose gate is high. Clear is never high together with either sample strobe.
- R4: Gate and clear line i (bit i of the vectors) belong to row i. Successive rows of a scan are numbered upward by one, from the start row to row ROWS-1.
- R5: In the cycle after `smp_b` of row ROWS-1 ends, `frame_done` is high for exactly one cycle. If `run` is still high, the setup phase of the start row begins in that same cycle.
- R6: A scan begins in the cycle after a rising clock edge that sees `run` high while the block is idle. If `run` is low when a row's `smp_b` ends, all outputs go low from the next cycle and stay low while `run` is low.
- R7: A clock edge that sees `pwr_down` high makes all outputs low from the next cycle, with no frame pulse. No scan starts while `pwr_down` is high.
- R8: The start row and the three phase lengths are captured when a scan begins. Changes to them during a scan have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Level; high to scan, low to stop after the current row |
| pwr_down | input | 1 | Immediate stop, all lines low |
| start_row | input | RW ($clog2(ROWS)) | First row of each scan (region access) |
| cfg_setup | input | LEN_W | Setup phase length in cycles |
| cfg_sample | input | LEN_W | Length of each sample phase in cycles |
| cfg_clear | input | LEN_W | Clear pulse length in cycles |
| gate | output | ROWS | One-hot row select lines |
| clr | output | ROWS | One-hot row clear lines |
| smp_a | output | 1 | First sample request (signal plus pedestal) |
| smp_b | output | 1 | Second sample request (pedestal only) |
| frame_done | output | 1 | One-cycle pulse after the last row of a scan |

## Verification
The embedded properties assume that all inputs are synchronous to `clk`, that `start_row` is below ROWS, and that `rst` is high for at least one edge before anything else is checked. The stimulus changes inputs only on falling edges. It keeps `start_row` inside the matrix and raises `rst` only at the very beginning. `run`, `pwr_down`, the start row and the phase lengths are moved freely in mid-row, because the design must tolerate those changes on its own.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_SMPA  = 3'd2,
        PH_CLEAR = 3'd3,
        PH_SMPB  = 3'd4
    } phase_e;

    // Order of phases inside one row (smp_b handled by the row logic)
    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_SETUP: return PH_SMPA;
            PH_SMPA:  return PH_CLEAR;
            PH_CLEAR: return PH_SMPB;
            default:  return PH_SETUP;
        endcase
    endfunction

    function automatic logic is_sampling(phase_e p);
        return (p == PH_SMPA) || (p == PH_SMPB);
    endfunction

endpackage

// File: rtl/rowseq_timer.sv
module rowseq_timer #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] eff_len;

    assign eff_len = (len == '0) ? LEN_W'(1) : len;
    assign expire  = active && (cnt == eff_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !active || expire)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < eff_len));

endmodule

// File: rtl/rowseq_fsm.sv
module rowseq_fsm
    import rowseq_pkg::*;
#(
    parameter int ROWS  = 64,
    parameter int LEN_W = 4,
    parameter int RW    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pwr_down,
    input  logic [RW-1:0]    start_row,
    input  logic [LEN_W-1:0] cfg_setup,
    input  logic [LEN_W-1:0] cfg_sample,
    input  logic [LEN_W-1:0] cfg_clear,
    input  logic             expire,
    output phase_e           phase,
    output logic [RW-1:0]    row,
    output logic [LEN_W-1:0] cur_len,
    output logic             frame_done
);
    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

    typedef struct packed {
        logic [RW-1:0]    base;
        logic [LEN_W-1:0] setup;
        logic [LEN_W-1:0] sample;
        logic [LEN_W-1:0] clear;
    } scan_cfg_t;

    scan_cfg_t cfg_q;

    always_comb begin
        case (phase)
            PH_SETUP:          cur_len = cfg_q.setup;
            PH_SMPA, PH_SMPB:  cur_len = cfg_q.sample;
            PH_CLEAR:          cur_len = cfg_q.clear;
            default:           cur_len = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            row        <= '0;
            cfg_q      <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (pwr_down) begin
                phase <= PH_IDLE;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        if (run) begin
                            phase        <= PH_SETUP;
                            row          <= start_row;
                            cfg_q.base   <= start_row;
                            cfg_q.setup  <= cfg_setup;
                            cfg_q.sample <= cfg_sample;
                            cfg_q.clear  <= cfg_clear;
                        end
                    end
                    PH_SMPB: begin
                        if (expire) begin
                            frame_done <= (row == LAST);
                            if (!run) begin
                                phase <= PH_IDLE;
                            end else begin
                                phase <= PH_SETUP;
                                row   <= (row == LAST) ? cfg_q.base : row + 1'b1;
                            end
                        end
                    end
                    default: begin
                        if (expire) phase <= phase_after(phase);
                    end
                endcase
            end
        end
    end

    // R4
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SMPB && expire && run && !pwr_down && row != LAST)
        |=> (row == $past(row) + 1'b1));

    // R5
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && phase != PH_IDLE) |-> (phase == PH_SETUP && row == cfg_q.base));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !run) |=> (phase == PH_IDLE));

    // R7
    pwr_stop_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (phase == PH_IDLE && !frame_done));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(cfg_q));

endmodule

// File: rtl/rowseq_lines.sv
module rowseq_lines
    import rowseq_pkg::*;
#(
    parameter int ROWS = 64,
    parameter int RW   = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_e          phase,
    input  logic [RW-1:0]   row,
    output logic [ROWS-1:0] gate,
    output logic [ROWS-1:0] clr,
    output logic            smp_a,
    output logic            smp_b
);
    logic busy;
    assign busy  = (phase != PH_IDLE);
    assign smp_a = (phase == PH_SMPA);
    assign smp_b = (phase == PH_SMPB);

    for (genvar i = 0; i < ROWS; i++) begin : g_line
        logic hit;
        assign hit     = (row == RW'(i));
        assign gate[i] = busy && hit;
        assign clr[i]  = (phase == PH_CLEAR) && hit;
    end

    // R3
    gate_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate));

    // R3
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));

    // R3
    clr_vs_smp_chk: assert property (@(posedge clk) disable iff (rst)
        (|clr) |-> (!smp_a && !smp_b && clr == gate));

    // R2
    smp_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_a || smp_b) |-> ($countones(gate) == 1));

endmodule

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
    import rowseq_pkg::*;
#(
    parameter int  ROWS  = 64,
    parameter int  LEN_W = 4,
    localparam int RW    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pwr_down,
    input  logic [RW-1:0]    start_row,
    input  logic [LEN_W-1:0] cfg_setup,
    input  logic [LEN_W-1:0] cfg_sample,
    input  logic [LEN_W-1:0] cfg_clear,
    output logic [ROWS-1:0]  gate,
    output logic [ROWS-1:0]  clr,
    output logic             smp_a,
    output logic             smp_b,
    output logic             frame_done
);
    phase_e           phase;
    logic [RW-1:0]    row;
    logic [LEN_W-1:0] cur_len;
    logic             expire;

    rowseq_fsm #(.ROWS(ROWS), .LEN_W(LEN_W), .RW(RW)) u_fsm (
        .clk(clk), .rst(rst), .run(run), .pwr_down(pwr_down),
        .start_row(start_row), .cfg_setup(cfg_setup),
        .cfg_sample(cfg_sample), .cfg_clear(cfg_clear),
        .expire(expire), .phase(phase), .row(row),
        .cur_len(cur_len), .frame_done(frame_done)
    );

    rowseq_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst(rst), .active(phase != PH_IDLE),
        .len(cur_len), .expire(expire)
    );

    rowseq_lines #(.ROWS(ROWS), .RW(RW)) u_lines (
        .clk(clk), .rst(rst), .phase(phase), .row(row),
        .gate(gate), .clr(clr), .smp_a(smp_a), .smp_b(smp_b)
    );

endmodule

// File: tb/rowseq_ctrl_test.sv
module rowseq_ctrl_test;
    localparam int ROWS  = 64;
    localparam int LEN_W = 4;
    localparam int RW    = $clog2(ROWS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             run = 1'b0;
    logic             pwr_down = 1'b0;
    logic [RW-1:0]    start_row = '0;
    logic [LEN_W-1:0] cfg_setup = '0, cfg_sample = '0, cfg_clear = '0;
    logic [ROWS-1:0]  gate, clr;
    logic             smp_a, smp_b, frame_done;

    int vectors = 0;
    int fails   = 0;
    bit ended   = 0;
    string tag  = "R1";

    always #4 clk = ~clk;

    rowseq_ctrl #(.ROWS(ROWS), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .run(run), .pwr_down(pwr_down),
        .start_row(start_row), .cfg_setup(cfg_setup),
        .cfg_sample(cfg_sample), .cfg_clear(cfg_clear),
        .gate(gate), .clr(clr), .smp_a(smp_a), .smp_b(smp_b),
        .frame_done(frame_done)
    );

    // Behavioural reference: 0 idle, 1 setup, 2 first sample, 3 clear, 4 second sample
    int m_ph = 0, m_row = 0, m_base = 0, m_cnt = 0, m_fd = 0;
    int m_len[1:4];

    function automatic int at_least_one(int v);
        return (v < 1) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        m_fd = 0;
        if (rst) begin
            m_ph = 0; m_cnt = 0;
        end else if (pwr_down) begin
            m_ph = 0; m_cnt = 0;
        end else if (m_ph == 0) begin
            if (run) begin
                m_ph = 1; m_cnt = 0;
                m_row = int'(start_row); m_base = int'(start_row);
                m_len[1] = at_least_one(int'(cfg_setup));
                m_len[2] = at_least_one(int'(cfg_sample));
                m_len[3] = at_least_one(int'(cfg_clear));
                m_len[4] = m_len[2];
            end
        end else if (m_cnt + 1 < m_len[m_ph]) begin
            m_cnt++;
        end else begin
            m_cnt = 0;
            if (m_ph < 4) m_ph++;
            else begin
                if (m_row == ROWS - 1) m_fd = 1;
                if (!run) m_ph = 0;
                else begin
                    m_ph = 1;
                    m_row = (m_row == ROWS - 1) ? m_base : m_row + 1;
                end
            end
        end
    end

    task automatic chk(string what, logic [ROWS-1:0] act, logic [ROWS-1:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            logic [ROWS-1:0] eg, ec;
            @(negedge clk);
            eg = (m_ph != 0) ? (ROWS'(1) << m_row) : '0;
            ec = (m_ph == 3) ? (ROWS'(1) << m_row) : '0;
            vectors++;
            chk("gate", gate, eg);
            chk("clr", clr, ec);
            chk("smp_a", ROWS'(smp_a), ROWS'(m_ph == 2));
            chk("smp_b", ROWS'(smp_b), ROWS'(m_ph == 4));
            chk("frame_done", ROWS'(frame_done), ROWS'(m_fd));
            // R3: independent one-hot and overlap check at the ports
            if ($countones(gate) > 1 || $countones(clr) > 1 || ((|clr) && (smp_a || smp_b))) begin
                fails++;
                $display("FAIL R3 exclusivity: actual gate=%h clr=%h expected at most one line, no overlap", gate, clr);
            end
        end
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset and idle state
        tag = "R1";
        step(3);
        rst = 1'b0;
        step(4);

        // R2: phase lengths 2/3/1 from row 61
        tag = "R2";
        cfg_setup = 4'd2; cfg_sample = 4'd3; cfg_clear = 4'd1; start_row = 6'd61;
        run = 1'b1;
        step(40);

        // R6: drop run mid-row; row finishes then stays idle
        tag = "R6";
        run = 1'b0;
        step(30);

        // R2: zero settings count as one cycle
        tag = "R2";
        cfg_setup = 4'd0; cfg_sample = 4'd0; cfg_clear = 4'd0; start_row = 6'd40;
        run = 1'b1;
        step(30);
        run = 1'b0;
        step(10);

        // R4: full scan from row 0 and wrap
        tag = "R4";
        cfg_setup = 4'd1; cfg_sample = 4'd1; cfg_clear = 4'd1; start_row = 6'd0;
        run = 1'b1;
        step(300);
        run = 1'b0;
        step(10);

        // R5: single-row region, frame pulse every row
        tag = "R5";
        cfg_setup = 4'd0; cfg_sample = 4'd0; cfg_clear = 4'd0; start_row = 6'd63;
        run = 1'b1;
        step(22);
        run = 1'b0;
        step(8);

        // R8: settings changed during a scan are ignored
        tag = "R8";
        cfg_setup = 4'd2; cfg_sample = 4'd2; cfg_clear = 4'd2; start_row = 6'd60;
        run = 1'b1;
        step(5);
        cfg_setup = 4'd5; cfg_sample = 4'd7; cfg_clear = 4'd3; start_row = 6'd10;
        step(100);

        // R7: power-down mid-scan with run still high
        tag = "R7";
        pwr_down = 1'b1;
        step(12);
        pwr_down = 1'b0;
        step(60);
        run = 1'b0;
        step(50);

        // R3: long clear, varied lengths, region from row 50
        tag = "R3";
        cfg_setup = 4'd3; cfg_sample = 4'd1; cfg_clear = 4'd4; start_row = 6'd50;
        run = 1'b1;
        step(200);
        run = 1'b0;
        step(20);

        finish_run();
    end
endmodule